// File: doc/BRIEF.md
# Execute-Stage Operand Bypass Selector

This block sits in front of the ALU in a five-stage in-order integer pipeline. Each cycle it looks at the source register indices of the instruction in the execute stage. It compares them with the destination of the two older instructions still in flight: the one in the memory stage and the one in the write-back stage. For each ALU operand it then picks a value. It can pass through the register-file read, or it can substitute the newer result held by a later stage. This lets a dependent instruction directly behind its producer proceed without waiting for write-back.

When a producer cannot supply its value in time, the block raises a stall request, and the surrounding pipeline holds the dependent instruction and inserts a bubble. This happens when a load sits in the memory stage and its data only appears after the memory access. Dependencies that a bypass can serve never stall. The block is purely combinational. Its inputs come straight from the pipeline registers and it drives the ALU operand inputs. All pins are plain control and data signals with no handshake, because the pipeline registers own the flow.

Top module: `opnd_bypass`

## Requirements
- R1: A source that matches no eligible producer gets select code 2'b00 and the operand equals that source's register-file read value.
- R2: A source that matches an eligible memory-stage producer gets select code 2'b01 and the operand equals the memory-stage result.
- R3: A source that matches only an eligible write-back producer gets select code 2'b10 and the operand equals the write-back result.
- R4: When both producers match the same source, the memory-stage (younger) value is chosen, select 2'b01.
- R5: A producer whose register-write enable is low never matches, including a memory-stage load.
- R6: A producer whose destination is register index 0 never matches, even with write enable set, including a memory-stage load.
- R7: Each operand is resolved on its own, so the two sources may take different selects in the same cycle.
- R8: The stall request is high exactly when the memory-stage producer is a load that matches at least one source; a write-back match alone never raises it.
- R9: Select code 2'b11 never appears on any operand.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ex_src | input | NUM_SRC x AW | Source register indices of the execute-stage instruction |
| rf_rdata | input | NUM_SRC x XLEN | Register-file read values for each source |
| mem_wen | input | 1 | Memory-stage instruction writes a register |
| mem_dst | input | AW | Memory-stage destination index |
| mem_is_load | input | 1 | Memory-stage instruction is a load |
| mem_result | input | XLEN | Memory-stage ALU result |
| wb_wen | input | 1 | Write-back instruction writes a register |
| wb_dst | input | AW | Write-back destination index |
| wb_result | input | XLEN | Write-back result value |
| opnd | output | NUM_SRC x XLEN | Resolved ALU operands |
| opnd_sel | output | NUM_SRC x 2 | Per-operand select: 00 register file, 01 memory stage, 10 write-back |
| stall_req | output | 1 | Request to hold the execute instruction for one cycle |

## Verification
Two functions can land in the same cycle: the youngest-wins priority between both producers, and the load-use stall. The bench provokes this by having a load in the memory stage and a write-back instruction target the same source register. It then expects the memory-stage select together with a raised stall. A second case has one operand served from write-back while the other operand hits a stalling load. In that case the bench checks that the stall does not disturb the other operand's write-back select and value.

// File: rtl/opnd_bypass_pkg.sv
package opnd_bypass_pkg;
  typedef enum logic [1:0] {
    SEL_RF  = 2'b00,
    SEL_MEM = 2'b01,
    SEL_WB  = 2'b10
  } byp_sel_e;
endpackage

// File: rtl/byp_match.sv
module byp_match #(
  parameter int AW = 5
) (
  input  logic [AW-1:0] src,
  input  logic          wen,
  input  logic [AW-1:0] dst,
  output logic          hit
);
  // register zero is hard-wired, so writes to it are never forwarded
  always_comb hit = wen && (dst != '0) && (dst == src);
endmodule

// File: rtl/byp_operand.sv
module byp_operand
  import opnd_bypass_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int AW   = 5
) (
  input  logic [AW-1:0]   src,
  input  logic [XLEN-1:0] rf_val,
  input  logic            mem_wen,
  input  logic [AW-1:0]   mem_dst,
  input  logic            mem_is_load,
  input  logic [XLEN-1:0] mem_result,
  input  logic            wb_wen,
  input  logic [AW-1:0]   wb_dst,
  input  logic [XLEN-1:0] wb_result,
  output logic [XLEN-1:0] val,
  output byp_sel_e        sel,
  output logic            load_hazard
);
  logic hit_mem, hit_wb;

  byp_match #(.AW(AW)) u_mem (.src(src), .wen(mem_wen), .dst(mem_dst), .hit(hit_mem));
  byp_match #(.AW(AW)) u_wb  (.src(src), .wen(wb_wen),  .dst(wb_dst),  .hit(hit_wb));

  // younger producer first
  always_comb begin
    if (hit_mem)     sel = SEL_MEM;
    else if (hit_wb) sel = SEL_WB;
    else             sel = SEL_RF;
  end

  always_comb begin
    unique case (sel)
      SEL_MEM: val = mem_result;
      SEL_WB:  val = wb_result;
      default: val = rf_val;
    endcase
  end

  // load data is not ready until after the memory access
  always_comb load_hazard = hit_mem && mem_is_load;
endmodule

// File: rtl/opnd_bypass.sv
module opnd_bypass
  import opnd_bypass_pkg::*;
#(
  parameter int XLEN    = 32,
  parameter int AW      = 5,
  parameter int NUM_SRC = 2
) (
  input  logic [NUM_SRC-1:0][AW-1:0]   ex_src,
  input  logic [NUM_SRC-1:0][XLEN-1:0] rf_rdata,
  input  logic                         mem_wen,
  input  logic [AW-1:0]                mem_dst,
  input  logic                         mem_is_load,
  input  logic [XLEN-1:0]              mem_result,
  input  logic                         wb_wen,
  input  logic [AW-1:0]                wb_dst,
  input  logic [XLEN-1:0]              wb_result,
  output logic [NUM_SRC-1:0][XLEN-1:0] opnd,
  output logic [NUM_SRC-1:0][1:0]      opnd_sel,
  output logic                         stall_req
);
  logic [NUM_SRC-1:0] hazard;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    byp_sel_e sel_g;
    byp_operand #(.XLEN(XLEN), .AW(AW)) u_op (
      .src        (ex_src[g]),
      .rf_val     (rf_rdata[g]),
      .mem_wen    (mem_wen),
      .mem_dst    (mem_dst),
      .mem_is_load(mem_is_load),
      .mem_result (mem_result),
      .wb_wen     (wb_wen),
      .wb_dst     (wb_dst),
      .wb_result  (wb_result),
      .val        (opnd[g]),
      .sel        (sel_g),
      .load_hazard(hazard[g])
    );
    assign opnd_sel[g] = sel_g;
  end

  always_comb stall_req = |hazard;

  // checks relating selector outputs to the mux and port values
  always_comb begin
    for (int i = 0; i < NUM_SRC; i++) begin
      assert_sel_legal_R9: assert (opnd_sel[i] != 2'b11);
      if (opnd_sel[i] == 2'b00) begin
        assert_rf_pass_R1: assert (opnd[i] == rf_rdata[i]);
      end
      if (opnd_sel[i] == 2'b01) begin
        assert_mem_val_R2: assert (opnd[i] == mem_result);
        assert_mem_elig_R5: assert (mem_wen && mem_dst != '0 && mem_dst == ex_src[i]);
      end
      if (opnd_sel[i] == 2'b10) begin
        assert_wb_val_R3: assert (opnd[i] == wb_result);
        assert_wb_elig_R6: assert (wb_wen && wb_dst != '0 && wb_dst == ex_src[i]);
      end
    end
    if (stall_req) begin
      assert_stall_cause_R8: assert (mem_is_load && mem_wen && (mem_dst != '0));
    end
  end
endmodule

// File: tb/sim_opnd_bypass.sv
module sim_opnd_bypass;
  localparam int XLEN = 32;
  localparam int AW   = 5;
  localparam int NS   = 2;
  localparam logic [XLEN-1:0] RF0 = 32'hA0A0_0001;
  localparam logic [XLEN-1:0] RF1 = 32'hB0B0_0002;
  localparam logic [XLEN-1:0] MV  = 32'hC0DE_0003;
  localparam logic [XLEN-1:0] WV  = 32'hD00D_0004;

  typedef struct packed {
    logic [4:0] s0, s1;
    logic       mwe;
    logic [4:0] md;
    logic       mld;
    logic       wwe;
    logic [4:0] wd;
    logic [1:0] e0, e1;
    logic       est;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VT [NV] = '{
    '{5'd1,  5'd2,  1'b0, 5'd0,  1'b0, 1'b0, 5'd0,  2'b00, 2'b00, 1'b0}, // R1
    '{5'd3,  5'd4,  1'b1, 5'd3,  1'b0, 1'b0, 5'd0,  2'b01, 2'b00, 1'b0}, // R2
    '{5'd3,  5'd4,  1'b0, 5'd0,  1'b0, 1'b1, 5'd4,  2'b00, 2'b10, 1'b0}, // R3
    '{5'd7,  5'd7,  1'b1, 5'd7,  1'b0, 1'b1, 5'd7,  2'b01, 2'b01, 1'b0}, // R4
    '{5'd5,  5'd6,  1'b0, 5'd5,  1'b0, 1'b0, 5'd6,  2'b00, 2'b00, 1'b0}, // R5
    '{5'd0,  5'd0,  1'b1, 5'd0,  1'b0, 1'b1, 5'd0,  2'b00, 2'b00, 1'b0}, // R6
    '{5'd8,  5'd9,  1'b1, 5'd8,  1'b0, 1'b1, 5'd9,  2'b01, 2'b10, 1'b0}, // R7
    '{5'd10, 5'd11, 1'b1, 5'd11, 1'b1, 1'b0, 5'd0,  2'b00, 2'b01, 1'b1}, // R8
    '{5'd12, 5'd13, 1'b1, 5'd14, 1'b1, 1'b1, 5'd12, 2'b10, 2'b00, 1'b0}, // R8 no match
    '{5'd15, 5'd15, 1'b1, 5'd15, 1'b1, 1'b1, 5'd15, 2'b01, 2'b01, 1'b1}, // R4 with R8
    '{5'd0,  5'd3,  1'b1, 5'd0,  1'b1, 1'b1, 5'd3,  2'b00, 2'b10, 1'b0}, // R6 load to x0
    '{5'd20, 5'd21, 1'b0, 5'd20, 1'b1, 1'b1, 5'd21, 2'b00, 2'b10, 1'b0}  // R5 load disabled
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic [NS-1:0][AW-1:0]   ex_src;
  logic [NS-1:0][XLEN-1:0] rf_rdata;
  logic                    mem_wen, mem_is_load, wb_wen;
  logic [AW-1:0]           mem_dst, wb_dst;
  logic [XLEN-1:0]         mem_result, wb_result;
  logic [NS-1:0][XLEN-1:0] opnd;
  logic [NS-1:0][1:0]      opnd_sel;
  logic                    stall_req;

  opnd_bypass #(.XLEN(XLEN), .AW(AW), .NUM_SRC(NS)) u0 (
    .ex_src(ex_src), .rf_rdata(rf_rdata),
    .mem_wen(mem_wen), .mem_dst(mem_dst), .mem_is_load(mem_is_load), .mem_result(mem_result),
    .wb_wen(wb_wen), .wb_dst(wb_dst), .wb_result(wb_result),
    .opnd(opnd), .opnd_sel(opnd_sel), .stall_req(stall_req)
  );

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  function automatic string tag_of(int k);
    case (k)
      0: return "R1";  1: return "R2";  2: return "R3";
      3: return "R4";  4: return "R5";  5: return "R6";
      6: return "R7";  7: return "R8";  8: return "R8";
      9: return "R4/R8"; 10: return "R6"; default: return "R5";
    endcase
  endfunction

  function automatic logic [XLEN-1:0] exp_val(logic [1:0] s, logic [XLEN-1:0] rf);
    case (s)
      2'b01:   return MV;
      2'b10:   return WV;
      default: return rf;
    endcase
  endfunction

  task automatic check(string req, string what, logic [XLEN-1:0] act, logic [XLEN-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic apply(logic [4:0] s0, logic [4:0] s1, logic mwe, logic [4:0] md,
                       logic mld, logic wwe, logic [4:0] wd);
    @(negedge clk);
    ex_src[0] = s0; ex_src[1] = s1;
    mem_wen = mwe; mem_dst = md; mem_is_load = mld;
    wb_wen = wwe; wb_dst = wd;
    #5;
  endtask

  task automatic judge(string req, logic [1:0] e0, logic [1:0] e1, logic est);
    check(req, "sel0", {30'd0, opnd_sel[0]}, {30'd0, e0});
    check(req, "sel1", {30'd0, opnd_sel[1]}, {30'd0, e1});
    check(req, "opnd0", opnd[0], exp_val(e0, RF0));
    check(req, "opnd1", opnd[1], exp_val(e1, RF1));
    check(req, "stall", {31'd0, stall_req}, {31'd0, est});
  endtask

  initial begin
    ex_src = '0; rf_rdata[0] = RF0; rf_rdata[1] = RF1;
    mem_wen = 1'b0; mem_dst = '0; mem_is_load = 1'b0; mem_result = MV;
    wb_wen = 1'b0; wb_dst = '0; wb_result = WV;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // idle pipeline after reset: R1 pass-through, no stall (R8)
    #5;
    judge("R1 idle", 2'b00, 2'b00, 1'b0);

    for (int k = 0; k < NV; k++) begin
      apply(VT[k].s0, VT[k].s1, VT[k].mwe, VT[k].md, VT[k].mld, VT[k].wwe, VT[k].wd);
      judge(tag_of(k), VT[k].e0, VT[k].e1, VT[k].est);
    end

    // highest register index, both producers match: R4
    apply(5'd31, 5'd30, 1'b1, 5'd31, 1'b0, 1'b1, 5'd31);
    judge("R4 top index", 2'b01, 2'b00, 1'b0);
    // load in MEM matches only operand 1 while WB serves operand 0: R7 with R8
    apply(5'd17, 5'd18, 1'b1, 5'd18, 1'b1, 1'b1, 5'd17);
    judge("R7/R8", 2'b10, 2'b01, 1'b1);
    // WB-only match on both operands never stalls: R8, R3
    apply(5'd22, 5'd22, 1'b0, 5'd22, 1'b1, 1'b1, 5'd22);
    judge("R3/R8", 2'b10, 2'b10, 1'b0);
    // back to no dependency: R1
    apply(5'd9, 5'd10, 1'b1, 5'd11, 1'b1, 1'b1, 5'd12);
    judge("R1", 2'b00, 2'b00, 1'b0);

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
      end
    join_any
    disable fork;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule